// File: doc/BRIEF.md
# Latch-Framed SPI Frame Capture

This block is a receive-only serial target that gathers one complete pixel frame into an on-chip byte buffer. The host frames each transfer with a shared open-drain latch line. It pulls the line low, clocks bytes in over a clock pin and a data pin, and then lets the line go high. Data is taken on the rising edge of the serial clock, most significant bit first. There is no output data path and there is no choice of clock polarity.

When the latch goes high and at least one whole byte has been captured, the block hands the buffer to a downstream transmitter. It raises a one-cycle `frame_ready_o` pulse, and the transmitter reads the bytes through a read port that has one cycle of latency. Until the transmitter pulses `tx_done_i`, the block pulls the latch line low itself, so the line reads as busy. The `tx_done_i` pulse clears the byte count and releases the line.

The serial clock, serial data and latch line are oversampled by the system clock through two-flop synchronisers. The serial clock must therefore stay well below a quarter of the system clock rate.

Top module: `latch_frame_rx`

## Requirements
- R1: After reset, `latch_pull_o` is 0, `byte_count_o` is 0 and `frame_ready_o` is 0.
- R2: During a frame, bits are taken on rising edges of `sclk_i`, most significant bit first. The n-th complete byte (counting from 0) is stored at buffer address n, and `byte_count_o` counts the stored bytes.
- R3: A frame begins only on a falling edge of the latch line seen while idle. The bit counter is cleared whenever the block is not capturing, so every frame starts byte-aligned.
- R4: Clock edges while the latch line is high and the block is idle change neither the buffer nor `byte_count_o`.
- R5: The buffer holds DEPTH bytes (450 by default). Bytes that arrive after it is full are dropped, `byte_count_o` stays at DEPTH, and the stored bytes are unchanged.
- R6: When the latch line rises with a non-zero count, `frame_ready_o` pulses for exactly one cycle, and `latch_pull_o` is 1 (line pulled low) from then until `tx_done_i`.
- R7: When the latch line rises with zero bytes captured, there is no `frame_ready_o` pulse and `latch_pull_o` stays 0.
- R8: `tx_done_i` while busy clears `byte_count_o` to 0 and sets `latch_pull_o` to 0. The next frame is stored again from address 0.
- R9: While busy, clock activity is ignored. `tx_done_i` outside the busy state is ignored, and the count is kept.
- R10: Bits left over at the end of a frame that do not make a full byte are dropped and not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from host |
| sdata_i | input | 1 | Serial data from host |
| latch_i | input | 1 | Sensed level of the open-drain latch line |
| latch_pull_o | output | 1 | 1 pulls the latch line low (busy) |
| frame_ready_o | output | 1 | One-cycle pulse: the buffer holds a frame |
| byte_count_o | output | 9 | Bytes stored in the current frame |
| rd_addr_i | input | 9 | Transmitter read address |
| rd_data_o | output | 8 | Buffer byte at rd_addr_i, one cycle later |
| tx_done_i | input | 1 | Pulse from the transmitter: frame sent |

## Verification
Each fault inside the block shows up at the ports in a known way:
- A bit counter that is not cleared shows as shifted byte values in the next frame. It appears at the first read-back from address 0.
- A wrong shift order or wrong address stepping shows in the read-back bytes once the frame is handed over.
- A missing saturation shows as a count past 450, or as a last stored byte that gets overwritten.
- A fault in the state handling shows at the latch pull output. It appears within a few cycles of the latch rise or of `tx_done_i`, as a missing or doubled ready pulse, a busy line that never releases, or a count that changes while busy.

// File: rtl/lfr_pkg.sv
package lfr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAPT = 2'd1,
    ST_BUSY = 2'd2
  } lfr_state_e;
endpackage

// File: rtl/lfr_sync.sv
module lfr_sync #(
  parameter int          N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= async_i[g];
        s2_q <= s1_q;
      end
    end
    assign sync_o[g] = s2_q;
  end
endmodule

// File: rtl/lfr_shift.sv
module lfr_shift #(
  parameter int BYTE_W = 8,
  localparam int BC_W  = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sclk_rise_i,
  input  logic              sdata_i,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-1:0] sr_q;
  logic [BC_W-1:0]   cnt_q;
  logic [BYTE_W-1:0] sr_nxt;

  assign sr_nxt = {sr_q[BYTE_W-2:0], sdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q       <= '0;
      cnt_q      <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      byte_vld_o <= 1'b0;
      if (!en_i) begin
        cnt_q <= '0;  // realign on every frame
      end else if (sclk_rise_i) begin
        sr_q  <= sr_nxt;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == BC_W'(BYTE_W - 1)) begin
          byte_vld_o <= 1'b1;
          byte_o     <= sr_nxt;
        end
      end
    end
  end

  AST_VLD_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> $past(en_i));  // R4
  AST_REALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_i) |=> !byte_vld_o);  // R10
endmodule

// File: rtl/lfr_buf.sv
module lfr_buf #(
  parameter int DEPTH  = 450,
  parameter int BYTE_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/lfr_ctrl.sv
module lfr_ctrl
  import lfr_pkg::*;
#(
  parameter int DEPTH  = 450,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             latch_fall_i,
  input  logic             latch_rise_i,
  input  logic             byte_vld_i,
  input  logic             tx_done_i,
  output logic             capt_o,
  output logic             we_o,
  output logic [AW-1:0]    waddr_o,
  output logic             pull_o,
  output logic             frame_ready_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  lfr_state_e state_q;
  logic [CNT_W-1:0] cnt_q;

  assign capt_o  = (state_q == ST_CAPT);
  assign we_o    = capt_o && byte_vld_i && (cnt_q < FULL);
  assign waddr_o = AW'(cnt_q);
  assign count_o = cnt_q;
  assign pull_o  = (state_q == ST_BUSY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      cnt_q         <= '0;
      frame_ready_o <= 1'b0;
    end else begin
      frame_ready_o <= 1'b0;
      if (we_o) cnt_q <= cnt_q + 1'b1;
      unique case (state_q)
        ST_IDLE: if (latch_fall_i) state_q <= ST_CAPT;
        ST_CAPT: if (latch_rise_i) begin
          if (cnt_q != '0 || we_o) begin
            state_q       <= ST_BUSY;
            frame_ready_o <= 1'b1;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_BUSY: if (tx_done_i) begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);  // R5
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == FULL && !tx_done_i) |=> cnt_q == FULL);  // R5
  AST_READY_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ready_o |=> !frame_ready_o);  // R6
  AST_READY_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ready_o |-> (cnt_q != '0 && pull_o));  // R7
  AST_RELEASE_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pull_o) |-> ($past(tx_done_i) && cnt_q == '0));  // R8
  AST_BUSY_COUNT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_o && !tx_done_i) |=> $stable(cnt_q));  // R9
endmodule

// File: rtl/latch_frame_rx.sv
module latch_frame_rx #(
  parameter int DEPTH  = 450,
  parameter int BYTE_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              latch_i,
  output logic              latch_pull_o,
  output logic              frame_ready_o,
  output logic [CNT_W-1:0]  byte_count_o,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              tx_done_i
);
  logic [2:0] sync;
  logic sclk_s, sdata_s, latch_s;
  logic sclk_p_q, latch_p_q;
  logic sclk_rise, latch_rise, latch_fall;
  logic capt, byte_vld, we;
  logic [BYTE_W-1:0] byte_d;
  logic [AW-1:0] waddr;

  lfr_sync #(.N(3), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({latch_i, sdata_i, sclk_i}),
    .sync_o (sync)
  );
  assign {latch_s, sdata_s, sclk_s} = sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_p_q  <= 1'b0;
      latch_p_q <= 1'b1;
    end else begin
      sclk_p_q  <= sclk_s;
      latch_p_q <= latch_s;
    end
  end

  assign sclk_rise  = sclk_s & ~sclk_p_q;
  assign latch_rise = latch_s & ~latch_p_q;
  assign latch_fall = ~latch_s & latch_p_q;

  lfr_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (capt),
    .sclk_rise_i(sclk_rise),
    .sdata_i    (sdata_s),
    .byte_vld_o (byte_vld),
    .byte_o     (byte_d)
  );

  lfr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .latch_fall_i (latch_fall),
    .latch_rise_i (latch_rise),
    .byte_vld_i   (byte_vld),
    .tx_done_i    (tx_done_i),
    .capt_o       (capt),
    .we_o         (we),
    .waddr_o      (waddr),
    .pull_o       (latch_pull_o),
    .frame_ready_o(frame_ready_o),
    .count_o      (byte_count_o)
  );

  lfr_buf #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_buf (
    .clk_i  (clk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(byte_d),
    .raddr_i(rd_addr_i),
    .rdata_o(rd_data_o)
  );

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!latch_pull_o && byte_count_o == '0));  // R1
  AST_START_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(capt) |-> $past(latch_fall));  // R3
endmodule

// File: tb/latch_frame_rx_tb_top.sv
module latch_frame_rx_tb_top;
  localparam int DEPTH = 450;

  logic clk = 0, rst_n = 0;
  logic sclk = 0, sdata = 0, host_low = 0, tx_done = 0;
  logic [8:0] rd_addr = '0;
  logic latch_line, pull, frame_ready;
  logic [8:0] count;
  logic [7:0] rd_data;
  int checks = 0, fails = 0, fr_pulses = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign latch_line = ~(host_low | pull);

  latch_frame_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata),
    .latch_i(latch_line), .latch_pull_o(pull), .frame_ready_o(frame_ready),
    .byte_count_o(count), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .tx_done_i(tx_done)
  );

  always @(posedge clk) if (rst_n && frame_ready) fr_pulses++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [7:0] v, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdata = v[i]; sclk = 0; wait_clk(4);
      sclk = 1; wait_clk(4);
    end
    sclk = 0; wait_clk(4);
  endtask

  task automatic read_byte(int a, output logic [7:0] v);
    @(negedge clk) rd_addr = 9'(a);
    @(negedge clk) v = rd_data;
  endtask

  task automatic pulse_done();
    @(negedge clk) tx_done = 1;
    @(negedge clk) tx_done = 0;
    wait_clk(4);
  endtask

  task automatic begin_frame();
    host_low = 1; wait_clk(6);
  endtask

  task automatic end_frame();
    host_low = 0; wait_clk(8);
  endtask

  task automatic t_reset();
    chk("R1 pull", pull, 0);
    chk("R1 count", count, 0);
    chk("R1 ready", fr_pulses, 0);
  endtask

  task automatic t_idle_clock();
    send_bits(8'hFF, 8);
    chk("R4 count idle", count, 0);
  endtask

  task automatic t_basic();
    logic [7:0] v;
    int p0 = fr_pulses;
    begin_frame();
    send_bits(8'hA5, 8); send_bits(8'h3C, 8);
    pulse_done();
    chk("R9 done ignored in capture", count, 2);
    send_bits(8'h81, 8);
    chk("R2 count", count, 3);
    end_frame();
    chk("R6 one pulse", fr_pulses - p0, 1);
    chk("R6 pull busy", pull, 1);
    chk("R6 line low", latch_line, 0);
    read_byte(0, v); chk("R2 byte0", v, 8'hA5);
    read_byte(1, v); chk("R2 byte1", v, 8'h3C);
    read_byte(2, v); chk("R2 byte2", v, 8'h81);
    send_bits(8'h77, 8);
    chk("R9 busy count", count, 3);
    chk("R6 still busy", pull, 1);
    read_byte(2, v); chk("R9 busy buffer", v, 8'h81);
    pulse_done();
    chk("R8 count cleared", count, 0);
    chk("R8 released", pull, 0);
  endtask

  task automatic t_empty();
    int p0 = fr_pulses;
    begin_frame();
    end_frame();
    chk("R7 no pulse", fr_pulses - p0, 0);
    chk("R7 released", pull, 0);
  endtask

  task automatic t_partial();
    logic [7:0] v;
    begin_frame();
    send_bits(8'h11, 8); send_bits(8'hF8, 5);
    end_frame();
    chk("R10 partial dropped", count, 1);
    pulse_done();
    begin_frame();
    send_bits(8'hC3, 8);
    end_frame();
    chk("R3 count", count, 1);
    read_byte(0, v);
    chk("R3 aligned from addr 0", v, 8'hC3);
    pulse_done();
  endtask

  task automatic t_full();
    logic [7:0] v;
    begin_frame();
    for (int i = 0; i < DEPTH + 2; i++) send_bits(8'(i) ^ 8'h5A, 8);
    chk("R5 saturated", count, DEPTH);
    end_frame();
    chk("R5 busy", pull, 1);
    read_byte(0, v); chk("R5 first", v, 8'h5A);
    read_byte(DEPTH - 1, v); chk("R5 last kept", v, 8'(DEPTH - 1) ^ 8'h5A);
    pulse_done();
    chk("R8 cleared after full", count, 0);
  endtask

  initial begin
    wait_clk(3); rst_n = 1; wait_clk(4);
    t_reset();
    t_idle_clock();
    t_basic();
    t_empty();
    t_partial();
    t_full();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule